// File: doc/BRIEF.md
# Wide-Prefix Local-Variable Dispatch Sequencer

This block is the microprogrammed front end of a byte-coded stack machine, limited to the two local-variable instructions (load and store) and the widening prefix that stretches their operand index from one byte to two. A program counter addresses a byte-wide code memory whose data comes back one cycle after the address. The sequencer reads an opcode, jumps to the microinstruction whose address equals the opcode value, reads the index byte or bytes, and then issues a single-cycle load or store request. Each request carries a local-variable word address equal to a base input plus the index.

The prefix opcode 0xC4 runs its own short microroutine. That routine reads the following opcode and dispatches into the upper half of the 512-word control store, at the opcode value plus 0x100. The widened routines build a 16-bit unsigned index from two bytes: the first byte is placed shifted left by eight, and the second byte is added into the cleared low byte. The routines then branch into the same tail microinstructions that the narrow forms use. Any opcode without a routine in the bank it was dispatched into sets a sticky error flag, and the sequencer freezes until reset.

Top module: `wide_dispatch_seq`

## Requirements
- R1: In reset, uaddr is 0x100 (the fetch-loop entry), pc and mem_addr are 0, and ld_stb, st_stb and err are 0.
- R2: code_addr always equals pc, and the byte at that address arrives on code_byte one cycle later. An instruction starts with uaddr at 0x100. Two cycles later uaddr equals the opcode for a defined opcode: 0x015 for the load opcode 0x15, 0x036 for the store opcode 0x36, and 0x0C4 for the prefix 0xC4.
- R3: Two cycles after a prefix routine starts (uaddr 0x0C4), uaddr equals 0x100 plus the next opcode: 0x115 for a widened load and 0x136 for a widened store.
- R4: For a narrow instruction, the single index byte is zero-extended, and mem_addr equals lv_base plus that index, modulo 2^16.
- R5: For a widened instruction, the index is the first index byte times 256 plus the second index byte, taken as unsigned, and mem_addr equals lv_base plus that index, modulo 2^16.
- R6: Each instruction produces exactly one strobe, lasting one cycle: ld_stb for a load and st_stb for a store, never both. The strobe appears 5 cycles after a narrow instruction's start (uaddr 0x100), or 8 cycles after a widened one's, in the same cycle in which the next instruction starts at uaddr 0x100.
- R7: A narrow instruction advances pc by 2 and a widened one by 4. While the strobe is high, pc holds the address of the next opcode.
- R8: An undefined opcode sets err. In the normal bank this is any opcode other than 0x15, 0x36 or 0xC4, and err rises 2 cycles after the instruction start. After a prefix, any opcode other than 0x15 or 0x36 is undefined, and err rises 4 cycles after the start. From then on err stays high, pc and uaddr hold, and no strobe is issued until reset.
- R9: When the widened index is built, the addition of the second byte never carries out of the low byte. An index whose low byte is 0xFF still yields exactly hi*256+0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lv_base | input | 16 | Base word address of the local-variable frame |
| code_byte | input | 8 | Code memory read data, one cycle after code_addr |
| code_addr | output | 16 | Code memory byte address |
| mem_addr | output | 16 | Local-variable word address of the current request |
| ld_stb | output | 1 | One-cycle load request |
| st_stb | output | 1 | One-cycle store request |
| pc | output | 16 | Program counter |
| uaddr | output | 9 | Address of the current microinstruction |
| err | output | 1 | Sticky undefined-opcode flag |

## Verification
A wrong dispatch address shows on uaddr two cycles after the opcode is presented. It then shows as a missing or mistimed strobe three or six cycles later. A mis-built index, for example a carry into the high byte or a sign extension, shows only in mem_addr at the strobe, so low bytes of 0x80 and 0xFF and base values near the top of the address space are driven on purpose. A wrong pc step or a missed freeze on error first shows in pc in the strobe cycle or in the error cycle. It then spreads into every later opcode read, which shifts all later uaddr and strobe checks.

// File: rtl/wds_pkg.sv
package wds_pkg;

    localparam int CS_AW = 9;
    localparam int OP_W  = 8;

    localparam logic [OP_W-1:0] OP_LOAD  = 8'h15;
    localparam logic [OP_W-1:0] OP_STORE = 8'h36;
    localparam logic [OP_W-1:0] OP_WIDE  = 8'hC4;

    // Entry points equal opcode values; tails sit at unreachable addresses.
    localparam logic [CS_AW-1:0] UA_MAIN1   = 9'h100;
    localparam logic [CS_AW-1:0] UA_MAIN2   = 9'h101;
    localparam logic [CS_AW-1:0] UA_LD1     = {1'b0, OP_LOAD};
    localparam logic [CS_AW-1:0] UA_LD2     = 9'h040;
    localparam logic [CS_AW-1:0] UA_LD_TAIL = 9'h041;
    localparam logic [CS_AW-1:0] UA_ST1     = {1'b0, OP_STORE};
    localparam logic [CS_AW-1:0] UA_ST2     = 9'h048;
    localparam logic [CS_AW-1:0] UA_ST_TAIL = 9'h049;
    localparam logic [CS_AW-1:0] UA_WIDE1   = {1'b0, OP_WIDE};
    localparam logic [CS_AW-1:0] UA_WIDE2   = 9'h050;
    localparam logic [CS_AW-1:0] UA_WLD1    = {1'b1, OP_LOAD};
    localparam logic [CS_AW-1:0] UA_WLD2    = 9'h058;
    localparam logic [CS_AW-1:0] UA_WLD3    = 9'h059;
    localparam logic [CS_AW-1:0] UA_WST1    = {1'b1, OP_STORE};
    localparam logic [CS_AW-1:0] UA_WST2    = 9'h05A;
    localparam logic [CS_AW-1:0] UA_WST3    = 9'h05B;

    typedef enum logic [1:0] {
        JAM_NONE,
        JAM_NARROW,
        JAM_WIDE
    } jam_e;

    typedef enum logic [1:0] {
        HOP_KEEP,
        HOP_NARROW,
        HOP_HIGH,
        HOP_ADD
    } hop_e;

    typedef enum logic [1:0] {
        MOP_NONE,
        MOP_LOAD,
        MOP_STORE
    } mop_e;

    typedef struct packed {
        logic             valid;
        logic [CS_AW-1:0] next;
        jam_e             jam;
        logic             fetch;
        hop_e             hop;
        mop_e             mop;
    } uinst_t;

    function automatic uinst_t mk(input logic [CS_AW-1:0] nxt, input jam_e jm,
                                  input logic fe, input hop_e hp, input mop_e mp);
        uinst_t w;
        w.valid = 1'b1;
        w.next  = nxt;
        w.jam   = jm;
        w.fetch = fe;
        w.hop   = hp;
        w.mop   = mp;
        return w;
    endfunction

    // Control store contents, computed; unlisted words are invalid.
    function automatic uinst_t cs_word(input logic [CS_AW-1:0] a);
        uinst_t w;
        w = '0;
        case (a)
            UA_MAIN1:   w = mk(UA_MAIN2,   JAM_NONE,   1'b1, HOP_KEEP,   MOP_NONE);
            UA_MAIN2:   w = mk(UA_MAIN1,   JAM_NARROW, 1'b0, HOP_KEEP,   MOP_NONE);
            UA_LD1:     w = mk(UA_LD2,     JAM_NONE,   1'b1, HOP_KEEP,   MOP_NONE);
            UA_LD2:     w = mk(UA_LD_TAIL, JAM_NONE,   1'b0, HOP_NARROW, MOP_NONE);
            UA_LD_TAIL: w = mk(UA_MAIN1,   JAM_NONE,   1'b0, HOP_KEEP,   MOP_LOAD);
            UA_ST1:     w = mk(UA_ST2,     JAM_NONE,   1'b1, HOP_KEEP,   MOP_NONE);
            UA_ST2:     w = mk(UA_ST_TAIL, JAM_NONE,   1'b0, HOP_NARROW, MOP_NONE);
            UA_ST_TAIL: w = mk(UA_MAIN1,   JAM_NONE,   1'b0, HOP_KEEP,   MOP_STORE);
            UA_WIDE1:   w = mk(UA_WIDE2,   JAM_NONE,   1'b1, HOP_KEEP,   MOP_NONE);
            UA_WIDE2:   w = mk(UA_MAIN1,   JAM_WIDE,   1'b0, HOP_KEEP,   MOP_NONE);
            UA_WLD1:    w = mk(UA_WLD2,    JAM_NONE,   1'b1, HOP_KEEP,   MOP_NONE);
            UA_WLD2:    w = mk(UA_WLD3,    JAM_NONE,   1'b1, HOP_HIGH,   MOP_NONE);
            UA_WLD3:    w = mk(UA_LD_TAIL, JAM_NONE,   1'b0, HOP_ADD,    MOP_NONE);
            UA_WST1:    w = mk(UA_WST2,    JAM_NONE,   1'b1, HOP_KEEP,   MOP_NONE);
            UA_WST2:    w = mk(UA_WST3,    JAM_NONE,   1'b1, HOP_HIGH,   MOP_NONE);
            UA_WST3:    w = mk(UA_ST_TAIL, JAM_NONE,   1'b0, HOP_ADD,    MOP_NONE);
            default:    w = '0;
        endcase
        return w;
    endfunction

    function automatic logic op_defined(input logic [OP_W-1:0] op, input logic wide_bank);
        if (wide_bank)
            return (op == OP_LOAD) || (op == OP_STORE);
        return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_WIDE);
    endfunction

endpackage

// File: rtl/wds_cstore.sv
module wds_cstore
    import wds_pkg::*;
(
    input  logic [CS_AW-1:0] addr,
    output uinst_t           word
);
    always_comb begin
        word = cs_word(addr);
    end
endmodule

// File: rtl/wds_useq.sv
module wds_useq
    import wds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  code_byte,
    input  uinst_t           raw_word,
    output logic [CS_AW-1:0] upc,
    output uinst_t           act_word,
    output logic             err
);
    logic             wide_sel;
    logic             op_ok;
    logic [CS_AW-1:0] jam_addr;

    assign wide_sel = (raw_word.jam == JAM_WIDE);
    assign op_ok    = op_defined(code_byte, wide_sel);
    assign jam_addr = {wide_sel, code_byte};

    // A halted sequencer issues only empty microinstructions.
    always_comb begin
        act_word = err ? uinst_t'('0) : raw_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upc <= UA_MAIN1;
            err <= 1'b0;
        end else if (!err) begin
            if (!raw_word.valid) begin
                err <= 1'b1;
            end else if (raw_word.jam != JAM_NONE) begin
                if (op_ok)
                    upc <= jam_addr;
                else
                    err <= 1'b1;
            end else begin
                upc <= raw_word.next;
            end
        end
    end

    // R3
    wide_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (!err && raw_word.jam == JAM_WIDE && op_ok) |=> (upc[CS_AW-1] == 1'b1));
endmodule

// File: rtl/wds_dpath.sv
module wds_dpath
    import wds_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int IDX_W = 16,
    parameter int AW    = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  uinst_t          uw,
    input  logic [OP_W-1:0] code_byte,
    input  logic [AW-1:0]   lv_base,
    output logic [PC_W-1:0] pc,
    output logic [AW-1:0]   mem_addr,
    output logic            ld_stb,
    output logic            st_stb
);
    localparam int HI_SH = OP_W;

    logic [IDX_W-1:0] hold;
    logic [IDX_W-1:0] byte_ext;

    assign byte_ext = IDX_W'(code_byte);

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else if (uw.fetch)
            pc <= pc + PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else begin
            unique case (uw.hop)
                HOP_NARROW: hold <= byte_ext;
                HOP_HIGH:   hold <= byte_ext << HI_SH;
                HOP_ADD:    hold <= hold + byte_ext;
                default:    hold <= hold;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            ld_stb   <= 1'b0;
            st_stb   <= 1'b0;
        end else begin
            ld_stb <= (uw.mop == MOP_LOAD);
            st_stb <= (uw.mop == MOP_STORE);
            if (uw.mop != MOP_NONE)
                mem_addr <= lv_base + AW'(hold);
        end
    end

    // R9
    no_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (uw.hop == HOP_ADD) |-> (hold[HI_SH-1:0] == '0));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ld_stb && st_stb));

    // R6
    strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_stb || st_stb) |=> !(ld_stb || st_stb));
endmodule

// File: rtl/wide_dispatch_seq.sv
module wide_dispatch_seq
    import wds_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int IDX_W = 16,
    parameter int AW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    lv_base,
    input  logic [OP_W-1:0]  code_byte,
    output logic [PC_W-1:0]  code_addr,
    output logic [AW-1:0]    mem_addr,
    output logic             ld_stb,
    output logic             st_stb,
    output logic [PC_W-1:0]  pc,
    output logic [CS_AW-1:0] uaddr,
    output logic             err
);
    uinst_t raw_word;
    uinst_t act_word;

    wds_cstore u_cstore (
        .addr (uaddr),
        .word (raw_word)
    );

    wds_useq u_useq (
        .clk       (clk),
        .rst       (rst),
        .code_byte (code_byte),
        .raw_word  (raw_word),
        .upc       (uaddr),
        .act_word  (act_word),
        .err       (err)
    );

    wds_dpath #(
        .PC_W  (PC_W),
        .IDX_W (IDX_W),
        .AW    (AW)
    ) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .uw        (act_word),
        .code_byte (code_byte),
        .lv_base   (lv_base),
        .pc        (pc),
        .mem_addr  (mem_addr),
        .ld_stb    (ld_stb),
        .st_stb    (st_stb)
    );

    assign code_addr = pc;

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> (err && $stable(pc) && $stable(uaddr)));

    // R6
    strobe_main_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_stb || st_stb) |-> (uaddr == UA_MAIN1));
endmodule

// File: tb/test_wide_dispatch_seq.sv
module test_wide_dispatch_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] lv_base = '0;
    logic [7:0]  code_byte = '0;
    logic [15:0] code_addr, mem_addr, pc;
    logic        ld_stb, st_stb, err;
    logic [8:0]  uaddr;

    always #10 clk = ~clk;

    wide_dispatch_seq i_wide_dispatch_seq (
        .clk(clk), .rst(rst), .lv_base(lv_base), .code_byte(code_byte),
        .code_addr(code_addr), .mem_addr(mem_addr), .ld_stb(ld_stb),
        .st_stb(st_stb), .pc(pc), .uaddr(uaddr), .err(err)
    );

    logic [7:0] cmem [0:1023];
    always @(posedge clk) code_byte <= cmem[code_addr[9:0]];

    int          nvec = 0;
    int          nbad = 0;
    int          kind [0:63];   // 0 load, 1 store, 2 wide load, 3 wide store
    logic [15:0] idx  [0:63];
    int          n_instr;
    logic [7:0]  bad_op;
    bit          bad_wide;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int ilen(input int k);
        return (k >= 2) ? 8 : 5;
    endfunction

    function automatic int ibytes(input int k);
        return (k >= 2) ? 4 : 2;
    endfunction

    function automatic logic [7:0] opc(input int k);
        return (k % 2 == 1) ? 8'h36 : 8'h15;
    endfunction

    function automatic logic [15:0] exp_addr(input logic [15:0] b, input logic [15:0] ix);
        return b + ix;
    endfunction

    task automatic load_program();
        int p = 0;
        for (int a = 0; a < 1024; a++) cmem[a] = 8'h00;
        for (int i = 0; i < n_instr; i++) begin
            if (kind[i] >= 2) begin
                cmem[p] = 8'hC4; p++;
                cmem[p] = opc(kind[i]); p++;
                cmem[p] = idx[i][15:8]; p++;
                cmem[p] = idx[i][7:0]; p++;
            end else begin
                cmem[p] = opc(kind[i]); p++;
                cmem[p] = idx[i][7:0]; p++;
            end
        end
        if (bad_wide) begin
            cmem[p] = 8'hC4;
            cmem[p+1] = bad_op;
        end else begin
            cmem[p] = bad_op;
        end
    endtask

    task automatic run_program();
        int          start = 0;
        int          i = 0;
        int          err_at = -1;
        logic [15:0] pcs = '0;
        logic [8:0]  frozen_ua = '0;
        bit          done = 0;
        load_program();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(uaddr == 9'h100, "R1 uaddr", 32'(uaddr), 32'h100);
        chk(pc == 16'h0, "R1 pc", 32'(pc), 32'h0);
        chk(mem_addr == 16'h0, "R1 mem_addr", 32'(mem_addr), 32'h0);
        chk(!ld_stb && !st_stb && !err, "R1 flags", {29'b0, ld_stb, st_stb, err}, 32'h0);
        rst = 1'b0;
        for (int cyc = 0; !done; cyc++) begin
            int  off = cyc - start;
            bit  e_ld = 0;
            bit  e_st = 0;
            if (i > 0 && off == 0) begin
                e_ld = (kind[i-1] % 2 == 0);
                e_st = (kind[i-1] % 2 == 1);
            end
            // R6 strobe presence and timing
            chk(ld_stb == e_ld && st_stb == e_st, "R6 strobes", {30'b0, ld_stb, st_stb}, {30'b0, e_ld, e_st});
            if (e_ld || e_st) begin
                if (kind[i-1] >= 2)
                    chk(mem_addr == exp_addr(lv_base, idx[i-1]), "R5 wide address",
                        32'(mem_addr), 32'(exp_addr(lv_base, idx[i-1])));
                else
                    chk(mem_addr == exp_addr(lv_base, {8'h00, idx[i-1][7:0]}), "R4 narrow address",
                        32'(mem_addr), 32'(exp_addr(lv_base, {8'h00, idx[i-1][7:0]})));
                // R7 pc points at next opcode during strobe
                chk(pc == pcs, "R7 pc", 32'(pc), 32'(pcs));
            end
            if (i < n_instr) begin
                if (off == 0)
                    chk(uaddr == 9'h100, "R2 fetch entry", 32'(uaddr), 32'h100);
                if (off == 2) begin
                    logic [8:0] ex = (kind[i] >= 2) ? 9'h0C4 : {1'b0, opc(kind[i])};
                    chk(uaddr == ex, "R2 dispatch", 32'(uaddr), 32'(ex));
                end
                if (kind[i] >= 2 && off == 4)
                    chk(uaddr == {1'b1, opc(kind[i])}, "R3 wide dispatch",
                        32'(uaddr), 32'({1'b1, opc(kind[i])}));
                chk(err == 1'b0, "R8 no error", 32'(err), 32'h0);
                if (off == ilen(kind[i]) - 1) begin
                    start = start + ilen(kind[i]);
                    pcs = pcs + 16'(ibytes(kind[i]));
                    i++;
                    if (i == n_instr) err_at = start + (bad_wide ? 4 : 2);
                end
            end else begin
                logic [15:0] epc = pcs + (bad_wide ? 16'd2 : 16'd1);
                bit e_err = (cyc >= err_at);
                // R8 sticky error and freeze
                chk(err == e_err, "R8 err", 32'(err), 32'(e_err));
                if (cyc == err_at) frozen_ua = uaddr;
                if (e_err) begin
                    chk(pc == epc, "R8 pc frozen", 32'(pc), 32'(epc));
                    chk(uaddr == frozen_ua, "R8 uaddr frozen", 32'(uaddr), 32'(frozen_ua));
                end
                if (cyc >= err_at + 12) done = 1;
            end
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] pick_bad(input bit wide);
        logic [7:0] b;
        do b = 8'($urandom % 256);
        while (b == 8'h15 || b == 8'h36 || (!wide && b == 8'hC4));
        return b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        // Directed: zero extension of 0x80 (R4), low byte 0xFF (R9), all forms
        n_instr = 5;
        kind[0] = 0; idx[0] = 16'h0080;
        kind[1] = 2; idx[1] = 16'h12FF;
        kind[2] = 1; idx[2] = 16'h00FF;
        kind[3] = 3; idx[3] = 16'hFFFF;
        kind[4] = 3; idx[4] = 16'h0100;
        bad_op = 8'h00; bad_wide = 0;
        lv_base = 16'h0000;
        run_program();
        // Directed: base near top wraps (R4, R5), double prefix is undefined (R8)
        n_instr = 4;
        kind[0] = 2; idx[0] = 16'hFFFF;
        kind[1] = 0; idx[1] = 16'h00FF;
        kind[2] = 1; idx[2] = 16'h0001;
        kind[3] = 2; idx[3] = 16'h80FF;
        bad_op = 8'hC4; bad_wide = 1;
        lv_base = 16'hFFF0;
        run_program();
        // Random programs
        for (int r = 0; r < 8; r++) begin
            n_instr = 10 + int'($urandom % 20);
            for (int i = 0; i < n_instr; i++) begin
                kind[i] = int'($urandom % 4);
                idx[i] = 16'($urandom);
                if ($urandom % 4 == 0) idx[i][7:0] = 8'hFF;
            end
            bad_wide = ($urandom % 2) == 1;
            bad_op = pick_bad(bad_wide);
            lv_base = 16'($urandom);
            run_program();
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule